// File: doc/BRIEF.md
# Flash Command Controller with Region Locks

This block sequences commands for a small on-chip flash array organised as rows of four pages. A host loads bytes into a single page buffer, then issues one-cycle commands with a byte address: erase a row, program a page from the buffer, erase or program an auxiliary row, clear the buffer, lock or unlock a region, set the security bit, and enter or leave a low-power state. Erasure works on a whole row and sets every byte to 0xFF. Programming touches only the addressed page and ANDs the buffer into the cells, so a page that was not erased first ends up holding the AND of the old and new data. A read port returns array contents combinationally.

The main array is cut into `REGIONS` equal regions, each with its own lock bit. The last `EE_ROWS` rows are a reserved section that the lock bits never block. An erase or program aimed at a locked region is refused: it raises the general and lock error flags and sets the security bit. The security bit has its own power-on reset `por_n`. A plain `rst_n` leaves it unchanged. While it is set, auxiliary erase and program commands are refused.

The controller is a three-state machine. `S_IDLE` accepts commands and raises `ready`. An accepted array operation moves it to `S_BUSY`, which counts `BUSY_CYC` cycles and then moves to `S_COMMIT`. `S_COMMIT` changes the array in one cycle and returns to `S_IDLE`. Refused commands and register-only commands (lock, unlock, buffer clear, security, low power) finish in `S_IDLE` without leaving it.

Top module: `flc_ctrl`

## Requirements
- R1: After `por_n` and `rst_n`, `ready` is 1, all error flags, `secure`, `low_power` and `lock_bits` are 0, and every main and auxiliary byte reads 0xFF.
- R2: Byte address = page*PAGE_BYTES + offset, and page = row*4 + position in row. Command `cmd_op`=1 (erase row) sets all four pages of the addressed row to 0xFF and leaves the other rows unchanged.
- R3: `cmd_op`=2 (write page) replaces each byte of the addressed page with (old AND buffer byte) and changes no other page. `cmd_op`=4 (write aux) does the same on aux page = page[1:0], and `cmd_op`=3 erases the 32-byte aux row to 0xFF. Aux reads use `rd_aux`=1 with the low bits of `rd_addr`.
- R4: After an array command is accepted, `ready` is 0 for exactly BUSY_CYC+1 cycles. Commands and buffer loads presented while `ready` is 0 are ignored.
- R5: `cmd_op`=5 sets and `cmd_op`=6 clears the lock bit of region page/(pages per region). The bit shows on `lock_bits`. `rst_n` clears all lock bits.
- R6: An erase or write page to a locked region outside the last EE_ROWS rows changes nothing and sets `err_any`, `err_lock` and `secure`. Rows inside the reserved section are never blocked.
- R7: Opcodes 0 and 11..15 are invalid. They set `err_any` and `err_prog` and change nothing.
- R8: While `secure` is 1, aux erase and aux write are refused with `err_any` and `err_lock`. `cmd_op`=8 sets `secure`. `rst_n` does not clear it; only `por_n` does.
- R9: `cmd_op`=7 sets every page-buffer byte to zero, so a later write page leaves that page all zero.
- R10: With `auto_mode`=1, loading the last unloaded byte of the buffer starts a write of the page named by the last `buf_addr`, one cycle after that load. A partially loaded buffer is never written automatically and needs `cmd_op`=2.
- R11: `err_clr` bit 0 clears `err_any`, bit 1 clears `err_lock` and bit 2 clears `err_prog` (write one to clear). A flag set in the same cycle stays set.
- R12: `cmd_op`=9 raises `low_power` and `cmd_op`=10 drops it. While it is high, every other command is refused with `err_any` and `err_prog`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of controller state |
| por_n | input | 1 | Active-low power-on reset of array contents and security bit |
| auto_mode | input | 1 | 1 = write starts by itself when the buffer is full |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 4 | Command code |
| cmd_addr | input | ADDR_W | Byte address of the command target |
| buf_we | input | 1 | Page-buffer byte load strobe |
| buf_addr | input | ADDR_W | Byte address of the loaded byte (low bits pick the buffer slot) |
| buf_data | input | 8 | Byte to load |
| rd_aux | input | 1 | Read selects the auxiliary row |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Read data, combinational |
| err_clr | input | 3 | Write-one-to-clear strobes for the error flags |
| ready | output | 1 | Controller idle and accepting commands |
| err_any | output | 1 | General error flag |
| err_lock | output | 1 | Lock or protection error flag |
| err_prog | output | 1 | Invalid command error flag |
| secure | output | 1 | Security bit |
| lock_bits | output | REGIONS | Region lock bits |
| low_power | output | 1 | Low-power state |

## Verification
A wrong state in the machine shows at `ready` within one cycle of an accepted command, because the low window must last exactly BUSY_CYC+1 cycles. A wrong target page or a missing AND shows at the read port after the next commit, so the bench compares the whole array with a model after each group of commands. Errors in lock, security or error-flag state show at the flag ports in the first cycle after the command that caused them. A wrong buffer state shows only at the next page write, which the bench therefore follows with a full array compare.

// File: rtl/flc_pkg.sv
package flc_pkg;
    typedef enum logic [3:0] {
        OP_NONE       = 4'd0,
        OP_ERASE_ROW  = 4'd1,
        OP_WRITE_PAGE = 4'd2,
        OP_ERASE_AUX  = 4'd3,
        OP_WRITE_AUX  = 4'd4,
        OP_LOCK       = 4'd5,
        OP_UNLOCK     = 4'd6,
        OP_BUF_CLR    = 4'd7,
        OP_SET_SEC    = 4'd8,
        OP_LP_ENTER   = 4'd9,
        OP_LP_EXIT    = 4'd10
    } cmd_e;

    typedef enum logic [1:0] {
        ACT_ERASE_MAIN,
        ACT_WRITE_MAIN,
        ACT_ERASE_AUX,
        ACT_WRITE_AUX
    } act_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_BUSY,
        S_COMMIT
    } state_e;

    // error flag bit positions
    localparam int ERR_ANY  = 0;
    localparam int ERR_LOCK = 1;
    localparam int ERR_PROG = 2;
    localparam logic [2:0] ERRV_LOCK = 3'b011;
    localparam logic [2:0] ERRV_PROG = 3'b101;
endpackage

// File: rtl/flc_pbuf.sv
module flc_pbuf #(
    parameter int PAGE_BYTES = 8,
    parameter int IDX_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic [7:0]              data_i,
    input  logic                    clr_i,
    input  logic                    consume_i,
    output logic [PAGE_BYTES*8-1:0] page_o,
    output logic                    full_o
);
    logic [7:0]            bytes_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] loaded_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) bytes_q[i] <= 8'h00;
            loaded_q <= '0;
        end else if (clr_i) begin
            for (int i = 0; i < PAGE_BYTES; i++) bytes_q[i] <= 8'h00;
            loaded_q <= '0;
        end else begin
            if (we_i) begin
                bytes_q[idx_i]  <= data_i;
                loaded_q[idx_i] <= 1'b1;
            end
            if (consume_i) loaded_q <= '0;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
        assign page_o[g*8 +: 8] = bytes_q[g];
    end

    assign full_o = &loaded_q;

    // R9: a clear leaves the buffer all zero
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (page_o == '0));
endmodule

// File: rtl/flc_lockctl.sv
module flc_lockctl #(
    parameter int REGIONS = 16,
    parameter int RIDX_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_n,
    input  logic               lock_set_i,
    input  logic               lock_clr_i,
    input  logic [RIDX_W-1:0]  region_i,
    input  logic               sec_set_i,
    output logic [REGIONS-1:0] lock_bits_o,
    output logic               secure_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_bits_o <= '0;
        end else if (lock_set_i) begin
            lock_bits_o[region_i] <= 1'b1;
        end else if (lock_clr_i) begin
            lock_bits_o[region_i] <= 1'b0;
        end
    end

    // security bit survives the ordinary reset
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) secure_o <= 1'b0;
        else if (sec_set_i) secure_o <= 1'b1;
    end

    // R8: once set, the security bit stays set until power-on reset
    p_secure_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
        secure_o |=> secure_o);
endmodule

// File: rtl/flc_array.sv
module flc_array import flc_pkg::*; #(
    parameter int NUM_ROWS   = 16,
    parameter int PAGE_BYTES = 8,
    parameter int IDX_W      = 3,
    parameter int PAGE_W     = 6,
    parameter int ADDR_W     = 9
) (
    input  logic                    clk,
    input  logic                    por_n,
    input  logic                    commit_i,
    input  act_e                    act_i,
    input  logic [PAGE_W-1:0]       page_i,
    input  logic [PAGE_BYTES*8-1:0] buf_i,
    input  logic                    rd_aux_i,
    input  logic [ADDR_W-1:0]       rd_addr_i,
    output logic [7:0]              rd_data_o
);
    localparam int NUM_BYTES = NUM_ROWS * 4 * PAGE_BYTES;
    localparam int AUX_W     = 2 + IDX_W;
    localparam int AUX_BYTES = 4 * PAGE_BYTES;

    logic [7:0] mem_q [NUM_BYTES];
    logic [7:0] aux_q [AUX_BYTES];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < NUM_BYTES; i++) mem_q[i] <= 8'hFF;
            for (int i = 0; i < AUX_BYTES; i++) aux_q[i] <= 8'hFF;
        end else if (commit_i) begin
            unique case (act_i)
                ACT_ERASE_MAIN: begin
                    for (int p = 0; p < 4; p++)
                        for (int b = 0; b < PAGE_BYTES; b++)
                            mem_q[{page_i[PAGE_W-1:2], 2'(p), IDX_W'(b)}] <= 8'hFF;
                end
                ACT_WRITE_MAIN: begin
                    for (int b = 0; b < PAGE_BYTES; b++)
                        mem_q[{page_i, IDX_W'(b)}] <=
                            mem_q[{page_i, IDX_W'(b)}] & buf_i[b*8 +: 8];
                end
                ACT_ERASE_AUX: begin
                    for (int i = 0; i < AUX_BYTES; i++) aux_q[i] <= 8'hFF;
                end
                ACT_WRITE_AUX: begin
                    for (int b = 0; b < PAGE_BYTES; b++)
                        aux_q[{page_i[1:0], IDX_W'(b)}] <=
                            aux_q[{page_i[1:0], IDX_W'(b)}] & buf_i[b*8 +: 8];
                end
                default: ;
            endcase
        end
    end

    assign rd_data_o = rd_aux_i ? aux_q[rd_addr_i[AUX_W-1:0]] : mem_q[rd_addr_i];

    // R2: first byte of an erased row holds 0xFF right after the commit
    p_erase_ff_r2: assert property (@(posedge clk) disable iff (!por_n)
        (commit_i && act_i == ACT_ERASE_MAIN) |=>
            (mem_q[{$past(page_i[PAGE_W-1:2]), 2'b00, IDX_W'(0)}] == 8'hFF));
endmodule

// File: rtl/flc_ctrl.sv
module flc_ctrl import flc_pkg::*; #(
    parameter int PAGE_BYTES = 8,
    parameter int NUM_ROWS   = 16,
    parameter int REGIONS    = 16,
    parameter int EE_ROWS    = 2,
    parameter int BUSY_CYC   = 6
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         por_n,
    input  logic                                         auto_mode,
    input  logic                                         cmd_valid,
    input  logic [3:0]                                   cmd_op,
    input  logic [$clog2(NUM_ROWS*4*PAGE_BYTES)-1:0]     cmd_addr,
    input  logic                                         buf_we,
    input  logic [$clog2(NUM_ROWS*4*PAGE_BYTES)-1:0]     buf_addr,
    input  logic [7:0]                                   buf_data,
    input  logic                                         rd_aux,
    input  logic [$clog2(NUM_ROWS*4*PAGE_BYTES)-1:0]     rd_addr,
    output logic [7:0]                                   rd_data,
    input  logic [2:0]                                   err_clr,
    output logic                                         ready,
    output logic                                         err_any,
    output logic                                         err_lock,
    output logic                                         err_prog,
    output logic                                         secure,
    output logic [REGIONS-1:0]                           lock_bits,
    output logic                                         low_power
);
    localparam int IDX_W     = $clog2(PAGE_BYTES);
    localparam int NUM_PAGES = NUM_ROWS * 4;
    localparam int PAGE_W    = $clog2(NUM_PAGES);
    localparam int ADDR_W    = PAGE_W + IDX_W;
    localparam int ROW_W     = PAGE_W - 2;
    localparam int RIDX_W    = $clog2(REGIONS);
    localparam int EE_FIRST  = NUM_ROWS - EE_ROWS;
    localparam int CNT_W     = $clog2(BUSY_CYC + 1);

    state_e              state_q;
    logic [CNT_W-1:0]    cnt_q;
    act_e                act_q;
    logic [PAGE_W-1:0]   page_q;
    logic [PAGE_W-1:0]   auto_page_q;
    logic [2:0]          err_q;
    logic                lp_q;

    logic                start;
    act_e                act_d;
    logic [PAGE_W-1:0]   page_d;
    logic [2:0]          err_set;
    logic                lk_set, lk_clr, sec_set, pb_clr, lp_set, lp_clr;
    logic                pb_consume, commit, pb_full;
    logic [RIDX_W-1:0]   reg_sel;
    logic [PAGE_W-1:0]   cmd_page;
    logic [ROW_W-1:0]    cmd_row, auto_row;
    logic                cmd_locked, auto_locked;
    logic [PAGE_BYTES*8-1:0] pb_page;
    logic                unused_low_bits;

    assign unused_low_bits = ^cmd_addr[IDX_W-1:0];

    assign cmd_page    = cmd_addr[ADDR_W-1:IDX_W];
    assign cmd_row     = cmd_page[PAGE_W-1:2];
    assign auto_row    = auto_page_q[PAGE_W-1:2];
    assign cmd_locked  = lock_bits[cmd_page[PAGE_W-1 -: RIDX_W]]
                         && (int'(cmd_row) < EE_FIRST);
    assign auto_locked = lock_bits[auto_page_q[PAGE_W-1 -: RIDX_W]]
                         && (int'(auto_row) < EE_FIRST);

    // ---------------- state register and transitions ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            act_q   <= ACT_ERASE_MAIN;
            page_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    state_q <= S_BUSY;
                    cnt_q   <= CNT_W'(BUSY_CYC - 1);
                    act_q   <= act_d;
                    page_q  <= page_d;
                end
                S_BUSY: begin
                    if (cnt_q == '0) state_q <= S_COMMIT;
                    else cnt_q <= cnt_q - 1'b1;
                end
                S_COMMIT: state_q <= S_IDLE;
                default:  state_q <= S_IDLE;
            endcase
        end
    end

    // ---------------- outputs and command decode ----------------
    always_comb begin
        start      = 1'b0;
        act_d      = ACT_ERASE_MAIN;
        page_d     = cmd_page;
        err_set    = 3'b000;
        lk_set     = 1'b0;
        lk_clr     = 1'b0;
        sec_set    = 1'b0;
        pb_clr     = 1'b0;
        lp_set     = 1'b0;
        lp_clr     = 1'b0;
        pb_consume = 1'b0;
        reg_sel    = cmd_page[PAGE_W-1 -: RIDX_W];
        commit     = (state_q == S_COMMIT);
        if (state_q == S_IDLE && cmd_valid) begin
            if (lp_q && cmd_op != OP_LP_EXIT) begin
                err_set = ERRV_PROG;
            end else begin
                unique case (cmd_e'(cmd_op))
                    OP_ERASE_ROW, OP_WRITE_PAGE: begin
                        if (cmd_locked) begin
                            err_set = ERRV_LOCK;
                            sec_set = 1'b1;
                        end else begin
                            start = 1'b1;
                            act_d = (cmd_op == OP_ERASE_ROW) ? ACT_ERASE_MAIN
                                                             : ACT_WRITE_MAIN;
                        end
                    end
                    OP_ERASE_AUX, OP_WRITE_AUX: begin
                        if (secure) begin
                            err_set = ERRV_LOCK;
                        end else begin
                            start = 1'b1;
                            act_d = (cmd_op == OP_ERASE_AUX) ? ACT_ERASE_AUX
                                                             : ACT_WRITE_AUX;
                        end
                    end
                    OP_LOCK:     lk_set  = 1'b1;
                    OP_UNLOCK:   lk_clr  = 1'b1;
                    OP_BUF_CLR:  pb_clr  = 1'b1;
                    OP_SET_SEC:  sec_set = 1'b1;
                    OP_LP_ENTER: lp_set  = 1'b1;
                    OP_LP_EXIT:  lp_clr  = 1'b1;
                    default:     err_set = ERRV_PROG;
                endcase
            end
        end else if (state_q == S_IDLE && auto_mode && pb_full && !lp_q) begin
            page_d = auto_page_q;
            if (auto_locked) begin
                err_set    = ERRV_LOCK;
                sec_set    = 1'b1;
                pb_consume = 1'b1;
            end else begin
                start = 1'b1;
                act_d = ACT_WRITE_MAIN;
            end
        end
        if (commit && (act_q == ACT_WRITE_MAIN || act_q == ACT_WRITE_AUX))
            pb_consume = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q       <= 3'b000;
            lp_q        <= 1'b0;
            auto_page_q <= '0;
        end else begin
            err_q <= (err_q & ~err_clr) | err_set;
            if (lp_set) lp_q <= 1'b1;
            else if (lp_clr) lp_q <= 1'b0;
            if (buf_we && state_q == S_IDLE) auto_page_q <= buf_addr[ADDR_W-1:IDX_W];
        end
    end

    assign ready     = (state_q == S_IDLE);
    assign err_any   = err_q[ERR_ANY];
    assign err_lock  = err_q[ERR_LOCK];
    assign err_prog  = err_q[ERR_PROG];
    assign low_power = lp_q;

    flc_pbuf #(.PAGE_BYTES(PAGE_BYTES), .IDX_W(IDX_W)) u_pbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (buf_we && state_q == S_IDLE),
        .idx_i     (buf_addr[IDX_W-1:0]),
        .data_i    (buf_data),
        .clr_i     (pb_clr),
        .consume_i (pb_consume),
        .page_o    (pb_page),
        .full_o    (pb_full)
    );

    flc_lockctl #(.REGIONS(REGIONS), .RIDX_W(RIDX_W)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_n       (por_n),
        .lock_set_i  (lk_set),
        .lock_clr_i  (lk_clr),
        .region_i    (reg_sel),
        .sec_set_i   (sec_set),
        .lock_bits_o (lock_bits),
        .secure_o    (secure)
    );

    flc_array #(.NUM_ROWS(NUM_ROWS), .PAGE_BYTES(PAGE_BYTES), .IDX_W(IDX_W),
                .PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_array (
        .clk       (clk),
        .por_n     (por_n),
        .commit_i  (commit),
        .act_i     (act_q),
        .page_i    (page_q),
        .buf_i     (pb_page),
        .rd_aux_i  (rd_aux),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    // ---------------- assertions ----------------
    logic [CNT_W:0] busy_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_run <= '0;
        else if (ready) busy_run <= '0;
        else if (busy_run != '1) busy_run <= busy_run + 1'b1;
    end

    // R4: the busy window never exceeds BUSY_CYC+1 cycles
    p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(busy_run) <= BUSY_CYC + 1);

    // R4: commands offered while busy leave locks and low-power state alone
    p_busy_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(lock_bits) && $stable(low_power)));

    // R6: a new lock error always comes with the general flag and the security bit
    p_lock_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_lock) |-> (err_any && secure));

    // R7: a new programming error always comes with the general flag
    p_prog_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_prog) |-> err_any);
endmodule

// File: tb/flc_ctrl_tb.sv
module flc_ctrl_tb;
    localparam int PB    = 8;
    localparam int NB    = 512;
    localparam int NAUX  = 32;
    localparam int BUSY  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0, por_n = 1'b0, auto_mode = 1'b0;
    logic cmd_valid = 1'b0;
    logic [3:0] cmd_op = 4'd0;
    logic [8:0] cmd_addr = '0;
    logic buf_we = 1'b0;
    logic [8:0] buf_addr = '0;
    logic [7:0] buf_data = '0;
    logic rd_aux = 1'b0;
    logic [8:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [2:0] err_clr = '0;
    logic ready, err_any, err_lock, err_prog, secure, low_power;
    logic [15:0] lock_bits;

    always #10 clk = ~clk;

    flc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .auto_mode(auto_mode),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
        .rd_aux(rd_aux), .rd_addr(rd_addr), .rd_data(rd_data),
        .err_clr(err_clr), .ready(ready), .err_any(err_any),
        .err_lock(err_lock), .err_prog(err_prog), .secure(secure),
        .lock_bits(lock_bits), .low_power(low_power)
    );

    // reference model state
    logic [7:0]  m_mem [NB];
    logic [7:0]  m_aux [NAUX];
    logic [7:0]  m_buf [PB];
    logic [7:0]  m_loaded;
    logic [5:0]  m_apage;
    logic [15:0] m_lock;
    logic        m_sec, m_lp;
    logic [2:0]  m_err;
    int vectors = 0;
    int fails = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req);
        chk(req, {12'd0, ready, low_power, secure, err_prog, err_lock, err_any, lock_bits},
                 {12'd0, 1'b1, m_lp, m_sec, m_err, m_lock});
    endtask

    task automatic mem_cmp(input string req);
        int bad = 0;
        logic [31:0] a = 0, e = 0;
        for (int i = 0; i < NB + NAUX; i++) begin
            rd_aux  = (i >= NB);
            rd_addr = (i >= NB) ? 9'(i - NB) : 9'(i);
            #1;
            if (rd_data !== ((i >= NB) ? m_aux[i-NB] : m_mem[i]) && bad == 0) begin
                bad = 1;
                a = {i[15:0], 8'd0, rd_data};
                e = {i[15:0], 8'd0, (i >= NB) ? m_aux[i-NB] : m_mem[i]};
            end
        end
        rd_aux = 1'b0;
        chk(req, a, e);
    endtask

    function automatic logic locked(input logic [5:0] pg);
        return m_lock[pg[5:2]] && (pg[5:2] < 4'd14);
    endfunction

    function automatic void m_write(input logic [5:0] pg);
        for (int b = 0; b < PB; b++) m_mem[pg*PB + b] &= m_buf[b];
        m_loaded = '0;
    endfunction

    function automatic void model_cmd(input logic [3:0] op, input logic [8:0] addr,
                                      input logic [2:0] clr);
        logic [5:0] pg = addr[8:3];
        logic [2:0] s = 3'b000;
        if (m_lp && op != 4'd10) s = 3'b101;
        else begin
            case (op)
                4'd1: if (locked(pg)) begin s = 3'b011; m_sec = 1'b1; end
                      else for (int b = 0; b < 4*PB; b++) m_mem[pg[5:2]*4*PB + b] = 8'hFF;
                4'd2: if (locked(pg)) begin s = 3'b011; m_sec = 1'b1; end
                      else m_write(pg);
                4'd3: if (m_sec) s = 3'b011;
                      else for (int b = 0; b < NAUX; b++) m_aux[b] = 8'hFF;
                4'd4: if (m_sec) s = 3'b011;
                      else begin
                          for (int b = 0; b < PB; b++) m_aux[pg[1:0]*PB + b] &= m_buf[b];
                          m_loaded = '0;
                      end
                4'd5: m_lock[pg[5:2]] = 1'b1;
                4'd6: m_lock[pg[5:2]] = 1'b0;
                4'd7: begin for (int b = 0; b < PB; b++) m_buf[b] = 8'h00; m_loaded = '0; end
                4'd8: m_sec = 1'b1;
                4'd9: m_lp = 1'b1;
                4'd10: m_lp = 1'b0;
                default: s = 3'b101;
            endcase
        end
        m_err = (m_err & ~clr) | s;
    endfunction

    task automatic wait_ready;
        for (int k = 0; k < 200 && !ready; k++) @(negedge clk);
    endtask

    task automatic send(input logic [3:0] op, input logic [8:0] addr, input logic [2:0] clr);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; err_clr = clr;
        model_cmd(op, addr, clr);
        @(negedge clk);
        cmd_valid = 1'b0; err_clr = 3'b000;
        wait_ready();
    endtask

    task automatic clr_err(input logic [2:0] clr);
        @(negedge clk); err_clr = clr; m_err &= ~clr;
        @(negedge clk); err_clr = 3'b000;
    endtask

    task automatic load(input logic [8:0] addr, input logic [7:0] d);
        @(negedge clk);
        buf_we = 1'b1; buf_addr = addr; buf_data = d;
        m_buf[addr[2:0]] = d; m_loaded[addr[2:0]] = 1'b1; m_apage = addr[8:3];
        @(negedge clk);
        buf_we = 1'b0;
        if (auto_mode && &m_loaded && !m_lp) begin
            if (locked(m_apage)) begin m_err |= 3'b011; m_sec = 1'b1; m_loaded = '0; end
            else m_write(m_apage);
            @(negedge clk);
            wait_ready();
        end
    endtask

    task automatic load_page(input logic [5:0] pg, input logic [7:0] seed);
        for (int b = 0; b < PB; b++) load({pg, 3'(b)}, seed ^ 8'(b * 37));
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int unsigned seed0;
        int lowc;
        seed0 = $urandom(32'h1F2E3D4C);
        for (int i = 0; i < NB; i++) m_mem[i] = 8'hFF;
        for (int i = 0; i < NAUX; i++) m_aux[i] = 8'hFF;
        for (int i = 0; i < PB; i++) m_buf[i] = 8'h00;
        m_loaded = '0; m_apage = '0; m_lock = '0; m_sec = 1'b0; m_lp = 1'b0; m_err = '0;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_flags("R1 reset flags");
        mem_cmp("R1 erased array after power-on");

        // R3: aux write and erase while security bit is clear
        load_page(6'd1, 8'h5A);
        send(4'd4, {6'd1, 3'd0}, 3'b000);
        mem_cmp("R3 aux write page 1");
        send(4'd3, 9'd0, 3'b000);
        mem_cmp("R3 aux erase");

        // R2/R3: page 0x1D sits in row 7 at position 1, byte address 0x0E8
        load_page(6'h1D, 8'hC3);
        send(4'd2, 9'h0E8, 3'b000);
        mem_cmp("R3 write page 0x1D only");
        load_page(6'h1D, 8'h3C);
        send(4'd2, 9'h0E8, 3'b000);
        mem_cmp("R3 write over unerased page ANDs");
        load_page(6'h1F, 8'h11);
        send(4'd2, 9'h0F8, 3'b000);
        send(4'd1, 9'h0F0, 3'b000);
        mem_cmp("R2 erase row 7 clears all four pages");

        // R9: buffer clear gives a zero page
        load_page(6'd5, 8'hEE);
        send(4'd7, 9'd0, 3'b000);
        send(4'd2, {6'd5, 3'd0}, 3'b000);
        mem_cmp("R9 cleared buffer writes zeros");

        // R4: busy window length and commands ignored while busy
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 4'd1; cmd_addr = {6'd5, 3'd0};
        model_cmd(4'd1, {6'd5, 3'd0}, 3'b000);
        @(negedge clk);
        cmd_op = 4'd5; cmd_addr = {6'd8, 3'd0};
        lowc = 0;
        while (!ready && lowc < 100) begin
            lowc++;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        cmd_valid = 1'b0;
        chk("R4 busy cycles", 32'(lowc), 32'(BUSY + 1));
        chk_flags("R4 lock command during busy ignored");
        mem_cmp("R4 erase completes");

        // R7/R11: invalid opcode and write-one-to-clear
        send(4'd13, 9'd0, 3'b000);
        chk_flags("R7 invalid opcode 13");
        send(4'd0, 9'd0, 3'b000);
        chk_flags("R7 invalid opcode 0");
        clr_err(3'b001);
        chk_flags("R11 clear general flag only");
        send(4'd15, 9'd0, 3'b100);
        chk_flags("R11 set wins over clear");
        clr_err(3'b111);
        chk_flags("R11 clear all flags");

        // R12: low power refuses other commands
        send(4'd9, 9'd0, 3'b000);
        chk_flags("R12 enter low power");
        send(4'd1, 9'h0E8, 3'b000);
        chk_flags("R12 command refused in low power");
        mem_cmp("R12 array unchanged in low power");
        send(4'd10, 9'd0, 3'b111);
        chk_flags("R12 exit low power");

        // R5/R6: region locks, row 3 = region 3, rows 14 and 15 reserved
        send(4'd5, {6'd12, 3'd0}, 3'b000);
        chk_flags("R5 lock region 3");
        load_page(6'd13, 8'h00);
        send(4'd2, {6'd13, 3'd0}, 3'b000);
        chk_flags("R6 write to locked region refused");
        mem_cmp("R6 locked page unchanged");
        load_page(6'd60, 8'h81);
        send(4'd5, {6'd60, 3'd0}, 3'b000);
        send(4'd2, {6'd60, 3'd0}, 3'b000);
        mem_cmp("R6 reserved row not blocked");
        send(4'd1, {6'd60, 3'd0}, 3'b000);
        mem_cmp("R6 reserved row erase");
        send(4'd6, {6'd12, 3'd0}, 3'b111);
        send(4'd2, {6'd13, 3'd0}, 3'b000);
        mem_cmp("R5 unlocked region writable");
        chk_flags("R5 unlock region 3");

        // R8: security bit blocks aux, survives reset
        send(4'd3, 9'd0, 3'b000);
        chk_flags("R8 aux erase refused while secure");
        mem_cmp("R8 aux unchanged");
        send(4'd5, {6'd20, 3'd0}, 3'b111);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_lock = '0; m_err = '0; m_lp = 1'b0; m_loaded = '0;
        for (int i = 0; i < PB; i++) m_buf[i] = 8'h00;
        @(negedge clk);
        chk_flags("R8 R5 reset keeps security clears locks");

        // R10: automatic write on full buffer, partial buffer stays put
        auto_mode = 1'b1;
        send(4'd1, {6'd40, 3'd0}, 3'b000);
        for (int b = 0; b < PB - 1; b++) load({6'd41, 3'(b)}, 8'(b + 8'h30));
        @(negedge clk);
        buf_we = 1'b1; buf_addr = {6'd41, 3'd7}; buf_data = 8'h77;
        m_buf[7] = 8'h77; m_loaded[7] = 1'b1;
        @(negedge clk); buf_we = 1'b0;
        @(negedge clk);
        chk("R10 auto write starts", {31'd0, ready}, 32'd0);
        m_write(6'd41);
        wait_ready();
        mem_cmp("R10 auto write result");
        for (int b = 0; b < 5; b++) load({6'd42, 3'(b)}, 8'(8'hA0 + b));
        repeat (20) @(negedge clk);
        mem_cmp("R10 partial page not written in auto mode");
        send(4'd2, {6'd42, 3'd0}, 3'b000);
        mem_cmp("R10 partial page needs explicit write");
        auto_mode = 1'b0;
        load_page(6'd43, 8'h0F);
        repeat (10) @(negedge clk);
        mem_cmp("R10 manual mode waits for command");

        // random phase
        for (int it = 0; it < 300; it++) begin
            int sel = $urandom_range(0, 9);
            logic [8:0] ad = 9'($urandom_range(0, 511));
            if (sel < 4) begin
                load(ad, 8'($urandom_range(0, 255)));
            end else begin
                logic [3:0] op;
                int w = $urandom_range(0, 19);
                if (w < 5) op = 4'd1;
                else if (w < 10) op = 4'd2;
                else if (w < 12) op = 4'd5;
                else if (w < 15) op = 4'd6;
                else if (w < 16) op = 4'd7;
                else if (w < 17) op = 4'($urandom_range(9, 10));
                else if (w < 18) op = 4'($urandom_range(3, 4));
                else op = 4'($urandom_range(11, 15));
                send(op, ad, 3'($urandom_range(0, 7)));
                chk_flags("R5 R6 R7 R12 random command flags");
            end
            if (it % 25 == 24) mem_cmp("R2 R3 random array compare");
        end
        send(4'd10, 9'd0, 3'b111);
        mem_cmp("R3 final array compare");
        chk_flags("R11 final flags");
        finish_run();
    end
endmodule